// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes one DDR3 channel from power-on to a usable state. When the init request arrives, it keeps the memory reset pin asserted for a programmable hold time. It then releases reset, waits a second programmable time and raises the clock enable. After a short settle time it writes the four mode registers and closes with two ZQ long calibration commands. When the second calibration window has elapsed it lowers `init_active` and raises `done`. Each delay is set in nanoseconds and converted to clock cycles from the clock-frequency parameter. One down-counter times every delay and is reloaded on each state change.

The mode-register contents come in already formatted on four 16-bit inputs. The sequencer adds the bank number and the chip-select index to each word, and forces the DLL-reset and interleaved-burst bits into MR0. Chip selects are scanned in ascending order and absent ones are skipped. A registered channel gets a full set of writes for every present chip select. An unbuffered channel gets a single set, for the first present chip select only. On an unbuffered channel, a chip select marked as mirrored has its address and bank bits pair-swapped.

Commands leave the block as a one-cycle `cmd_valid` strobe with a 24-bit `cmd_addr`. The sequencer then holds until `cmd_ack` comes back and waits a fixed gap before the next step.

States: `ST_IDLE` and `ST_DONE` wait for a request and go to `ST_RST_HOLD`. `ST_RST_HOLD` goes to `ST_CKE_WAIT` when its timer ends. `ST_CKE_WAIT` goes to `ST_CKE_SETTLE` when its timer ends. `ST_CKE_SETTLE` goes to `ST_CS_SCAN` when its timer ends. `ST_CS_SCAN` goes to `ST_MRS_ISSUE` on a present chip select. After index 7 it goes to `ST_ZQ_ISSUE`; otherwise it steps the index and stays. `ST_MRS_ISSUE` goes to `ST_MRS_ACK`, which goes to `ST_MRS_GAP` on acknowledge. `ST_MRS_GAP` leads to the next mode register, to `ST_CS_SCAN`, or to `ST_ZQ_ISSUE`. `ST_ZQ_ISSUE` goes to `ST_ZQ_ACK`, which goes to `ST_ZQ_GAP` on acknowledge. `ST_ZQ_GAP` goes back to `ST_ZQ_ISSUE` once, then to `ST_DONE`.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mem_rst_n`, `cke`, `cmd_valid`, `init_active` and `done` are all 0.
- R2: `init_active` rises on the edge that samples `init_req` in idle. `mem_rst_n` rises exactly ceil(RST_HOLD_NS*CLK_MHZ/1000) cycles later. `cke` rises exactly ceil(CKE_WAIT_NS*CLK_MHZ/1000) cycles after that.
- R3: The first command appears at least ceil(CKE_SETTLE_NS*CLK_MHZ/1000)+1 cycles after `cke` rises.
- R4: Each chip select gets mode-register writes to banks 2, 3, 1, 0, in that order. The command word holds the 16-bit register value in bits 15:0, the bank in bits 17:16 and the chip-select index in bits 22:20, with all other bits 0. In the bank-0 word, bits 8 and 3 are forced to 1.
- R5: On an unbuffered channel (`rdimm`=0), if the chip select's bit in `cs_mirror` is set, the word has bit pairs 3/4, 5/6, 7/8 and 16/17 exchanged.
- R6: On a registered channel (`rdimm`=1), every present chip select gets its writes, in ascending index order, and no word is swapped.
- R7: On an unbuffered channel, only the lowest present chip select gets mode-register writes.
- R8: `cmd_valid` is high for exactly one cycle per command. After the cycle in which `cmd_ack` is high for a mode-register write, at least 12 idle cycles pass before the next command.
- R9: After the last mode-register write, exactly two ZQ commands follow. Each has `cmd_is_zq`=1 and `cmd_addr`=24'h000400. The second ZQ command comes exactly 513 cycles after the acknowledge cycle of the first.
- R10: `done` rises and `init_active` falls exactly 513 cycles after the acknowledge cycle of the second ZQ command.
- R11: An `init_req` pulse while `init_active` is high is ignored: `mem_rst_n` stays high and the command stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_req | input | 1 | Start request, taken in idle or done |
| mr0_val | input | 16 | Formatted MR0 contents |
| mr1_val | input | 16 | Formatted MR1 contents |
| mr2_val | input | 16 | Formatted MR2 contents |
| mr3_val | input | 16 | Formatted MR3 contents |
| cs_present | input | 8 | Populated chip selects |
| cs_mirror | input | 8 | Chip selects with mirrored address wiring |
| rdimm | input | 1 | 1 = registered channel |
| cmd_ack | input | 1 | Command accepted by the command path |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_is_zq | output | 1 | Command is ZQ long calibration |
| cmd_addr | output | 24 | Command address word |
| mem_rst_n | output | 1 | Memory reset pin, active low |
| cke | output | 1 | Clock enable pin |
| init_active | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |

## Verification
The mirrored-swap path is the hardest case to reach. It needs an unbuffered channel whose first present chip select is marked as mirrored; a mirror bit on any later chip select is never used. The bench builds that case by leaving chip selects 0 and 1 absent and marking chip select 2 as mirrored. The register values it uses differ between bits 3/4, 5/6 and 7/8, so a swap that is wrong or missing changes the word. A second hard case is an init request that lands mid-sequence. The bench sends one while `cke` is already high and checks that the reset pin and the command stream are not disturbed.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_CKE_WAIT,
        ST_CKE_SETTLE,
        ST_CS_SCAN,
        ST_MRS_ISSUE,
        ST_MRS_ACK,
        ST_MRS_GAP,
        ST_ZQ_ISSUE,
        ST_ZQ_ACK,
        ST_ZQ_GAP,
        ST_DONE
    } seq_state_t;

    localparam int CMD_W   = 24;
    localparam int MRV_W   = 16;
    localparam int ZQ_BIT  = 10;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ddr3_init_mrs_word.sv
module ddr3_init_mrs_word
    import ddr3_init_pkg::*;
#(
    parameter int CSW = 3
) (
    input  logic [MRV_W-1:0] value,
    input  logic [1:0]       bank,
    input  logic [CSW-1:0]   cs,
    input  logic             swap,
    output logic [CMD_W-1:0] word
);
    logic [CMD_W-1:0] raw;

    // partner bit for the mirrored wiring of address and bank lines
    function automatic int partner(input int b);
        case (b)
            3: return 4;   4: return 3;
            5: return 6;   6: return 5;
            7: return 8;   8: return 7;
            16: return 17; 17: return 16;
            default: return b;
        endcase
    endfunction

    always_comb begin
        raw = '0;
        raw[MRV_W-1:0] = value | ((bank == 2'd0) ? 16'h0108 : 16'h0000);
        raw[17:16]     = bank;
        raw[20 +: CSW] = cs;
    end

    for (genvar g = 0; g < CMD_W; g++) begin : g_bit
        localparam int SRC = partner(g);
        assign word[g] = swap ? raw[SRC] : raw[g];
    end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int CLK_MHZ       = 250,
    parameter int RST_HOLD_NS   = 200000,
    parameter int CKE_WAIT_NS   = 500000,
    parameter int CKE_SETTLE_NS = 360,
    parameter int MOD_GAP_CLKS  = 12,
    parameter int ZQ_WAIT_CLKS  = 512,
    parameter int NUM_CS        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_req,
    input  logic [15:0]       mr0_val,
    input  logic [15:0]       mr1_val,
    input  logic [15:0]       mr2_val,
    input  logic [15:0]       mr3_val,
    input  logic [7:0]        cs_present,
    input  logic [7:0]        cs_mirror,
    input  logic              rdimm,
    input  logic              cmd_ack,
    output logic              cmd_valid,
    output logic              cmd_is_zq,
    output logic [23:0]       cmd_addr,
    output logic              mem_rst_n,
    output logic              cke,
    output logic              init_active,
    output logic              done
);
    localparam int N_RST  = ns_to_cyc(RST_HOLD_NS, CLK_MHZ);
    localparam int N_CKE  = ns_to_cyc(CKE_WAIT_NS, CLK_MHZ);
    localparam int N_SET  = ns_to_cyc(CKE_SETTLE_NS, CLK_MHZ);
    localparam int N_MAX1 = (N_RST > N_CKE) ? N_RST : N_CKE;
    localparam int N_MAX2 = (N_MAX1 > ZQ_WAIT_CLKS) ? N_MAX1 : ZQ_WAIT_CLKS;
    localparam int TW     = $clog2(N_MAX2 + 1);
    localparam int CSW    = $clog2(NUM_CS);
    localparam logic [CSW-1:0] CS_LAST = CSW'(NUM_CS - 1);

    seq_state_t     state, state_nx;
    logic [CSW-1:0] cs_idx;
    logic [1:0]     mr_step;
    logic           zq_second;
    logic           seq_clr, cs_inc, mr_inc, zq_set;
    logic           tmr_load, tmr_zero;
    logic [TW-1:0]  tmr_val;
    logic [1:0]     bank;
    logic [15:0]    mr_sel;
    logic [23:0]    mrs_word;

    // next-state and sequencing decisions
    always_comb begin
        state_nx = state;
        seq_clr  = 1'b0;
        cs_inc   = 1'b0;
        mr_inc   = 1'b0;
        zq_set   = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: if (init_req) begin
                state_nx = ST_RST_HOLD;
                seq_clr  = 1'b1;
            end
            ST_RST_HOLD:   if (tmr_zero) state_nx = ST_CKE_WAIT;
            ST_CKE_WAIT:   if (tmr_zero) state_nx = ST_CKE_SETTLE;
            ST_CKE_SETTLE: if (tmr_zero) state_nx = ST_CS_SCAN;
            ST_CS_SCAN: begin
                if (cs_present[cs_idx])     state_nx = ST_MRS_ISSUE;
                else if (cs_idx == CS_LAST) state_nx = ST_ZQ_ISSUE;
                else                        cs_inc   = 1'b1;
            end
            ST_MRS_ISSUE: state_nx = ST_MRS_ACK;
            ST_MRS_ACK:   if (cmd_ack) state_nx = ST_MRS_GAP;
            ST_MRS_GAP: if (tmr_zero) begin
                if (mr_step != 2'd3) begin
                    state_nx = ST_MRS_ISSUE;
                    mr_inc   = 1'b1;
                end else if (!rdimm || cs_idx == CS_LAST) begin
                    state_nx = ST_ZQ_ISSUE;
                end else begin
                    state_nx = ST_CS_SCAN;
                    cs_inc   = 1'b1;
                end
            end
            ST_ZQ_ISSUE: state_nx = ST_ZQ_ACK;
            ST_ZQ_ACK:   if (cmd_ack) state_nx = ST_ZQ_GAP;
            ST_ZQ_GAP: if (tmr_zero) begin
                state_nx = zq_second ? ST_DONE : ST_ZQ_ISSUE;
                zq_set   = 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and sequence position
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cs_idx    <= '0;
            mr_step   <= '0;
            zq_second <= 1'b0;
        end else begin
            state <= state_nx;
            if (seq_clr) begin
                cs_idx    <= '0;
                mr_step   <= '0;
                zq_second <= 1'b0;
            end
            if (cs_inc) begin
                cs_idx  <= cs_idx + 1'b1;
                mr_step <= '0;
            end
            if (mr_inc) mr_step   <= mr_step + 1'b1;
            if (zq_set) zq_second <= 1'b1;
        end
    end

    // shared delay counter, reloaded on every state change
    always_comb begin
        tmr_load = (state_nx != state);
        unique case (state_nx)
            ST_RST_HOLD:   tmr_val = TW'(N_RST - 1);
            ST_CKE_WAIT:   tmr_val = TW'(N_CKE - 1);
            ST_CKE_SETTLE: tmr_val = TW'(N_SET - 1);
            ST_MRS_GAP:    tmr_val = TW'(MOD_GAP_CLKS - 1);
            ST_ZQ_GAP:     tmr_val = TW'(ZQ_WAIT_CLKS - 1);
            default:       tmr_val = '0;
        endcase
    end

    ddr3_init_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    // step 0..3 -> bank 2,3,1,0
    assign bank = {~mr_step[1], mr_step[1] ^ mr_step[0]};

    always_comb begin
        unique case (bank)
            2'd0:    mr_sel = mr0_val;
            2'd1:    mr_sel = mr1_val;
            2'd2:    mr_sel = mr2_val;
            default: mr_sel = mr3_val;
        endcase
    end

    ddr3_init_mrs_word #(.CSW(CSW)) u_word (
        .value (mr_sel),
        .bank  (bank),
        .cs    (cs_idx),
        .swap  (cs_mirror[cs_idx] && !rdimm),
        .word  (mrs_word)
    );

    // outputs decoded from state
    always_comb begin
        mem_rst_n   = !(state == ST_IDLE || state == ST_RST_HOLD);
        cke         = !(state == ST_IDLE || state == ST_RST_HOLD || state == ST_CKE_WAIT);
        init_active = !(state == ST_IDLE || state == ST_DONE);
        done        = (state == ST_DONE);
        cmd_valid   = (state == ST_MRS_ISSUE) || (state == ST_ZQ_ISSUE);
        cmd_is_zq   = (state == ST_ZQ_ISSUE);
        cmd_addr    = '0;
        if (state == ST_MRS_ISSUE)     cmd_addr = mrs_word;
        else if (state == ST_ZQ_ISSUE) cmd_addr[ZQ_BIT] = 1'b1;
    end
endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_is_zq,
    input logic [23:0] cmd_addr,
    input logic        mem_rst_n,
    input logic        cke,
    input logic        init_active,
    input logic        done
);
    // R2: clock enable never high while memory reset is asserted
    a_r2_cke_after_reset: assert property (@(posedge clk) disable iff (rst)
        cke |-> mem_rst_n);

    // R8: strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R3: commands only with clock enable high
    a_r3_cmd_needs_cke: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cke);

    // R9: calibration word carries only bit 10
    a_r9_zq_word: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_is_zq) |-> (cmd_addr == 24'h000400));

    // R10: finished means quiet
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cmd_valid && !init_active && cke));
endmodule

bind ddr3_init_seq ddr3_init_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_is_zq   (cmd_is_zq),
    .cmd_addr    (cmd_addr),
    .mem_rst_n   (mem_rst_n),
    .cke         (cke),
    .init_active (init_active),
    .done        (done)
);

// File: tb/ddr3_init_seq_tb.sv
module ddr3_init_seq_tb;
    localparam int N_RST = 100;  // 400 ns at 250 MHz
    localparam int N_CKE = 200;  // 800 ns
    localparam int N_SET = 90;   // 360 ns

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_req = 1'b0;
    logic [15:0] mr0_val = 16'h1C61, mr1_val = 16'h0244;
    logic [15:0] mr2_val = 16'h0098, mr3_val = 16'h0004;
    logic [7:0]  cs_present = '0, cs_mirror = '0;
    logic        rdimm = 1'b0;
    logic        cmd_ack = 1'b0;
    logic        cmd_valid, cmd_is_zq, mem_rst_n, cke, init_active, done;
    logic [23:0] cmd_addr;

    int tests = 0, fails = 0, cyc = 0;
    logic [23:0] q_addr[$];
    bit          q_zq[$];
    string       tag = "R4";

    // monitor state
    int  t_act, t_rstn, t_cke, last_ack, ack_due, n_mrs;
    bit  first_cmd, last_zq, cur_zq, rst_fell;
    bit  p_act, p_rstn, p_cke, p_valid, p_done;

    ddr3_init_seq #(
        .CLK_MHZ(250), .RST_HOLD_NS(400), .CKE_WAIT_NS(800), .CKE_SETTLE_NS(360)
    ) u_dut (
        .clk(clk), .rst(rst), .init_req(init_req),
        .mr0_val(mr0_val), .mr1_val(mr1_val), .mr2_val(mr2_val), .mr3_val(mr3_val),
        .cs_present(cs_present), .cs_mirror(cs_mirror), .rdimm(rdimm),
        .cmd_ack(cmd_ack), .cmd_valid(cmd_valid), .cmd_is_zq(cmd_is_zq),
        .cmd_addr(cmd_addr), .mem_rst_n(mem_rst_n), .cke(cke),
        .init_active(init_active), .done(done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(int cs, int bank, logic [15:0] v, bit sw);
        logic [23:0] w;
        logic t;
        int pairs[4] = '{3, 5, 7, 16};
        w = {8'h00, v};
        if (bank == 0) begin w[8] = 1'b1; w[3] = 1'b1; end
        w[17:16] = bank[1:0];
        w[22:20] = cs[2:0];
        if (sw) foreach (pairs[k]) begin
            t = w[pairs[k]]; w[pairs[k]] = w[pairs[k]+1]; w[pairs[k]+1] = t;
        end
        return w;
    endfunction

    task automatic build_expect();
        int order[4] = '{2, 3, 1, 0};
        logic [15:0] vals[4];
        vals = '{mr0_val, mr1_val, mr2_val, mr3_val};
        q_addr.delete(); q_zq.delete();
        for (int cs = 0; cs < 8; cs++) begin
            if (cs_present[cs]) begin
                foreach (order[k]) begin
                    q_addr.push_back(exp_word(cs, order[k], vals[order[k]],
                                              cs_mirror[cs] && !rdimm));
                    q_zq.push_back(1'b0);
                end
                if (!rdimm) break;
            end
        end
        repeat (2) begin q_addr.push_back(24'h000400); q_zq.push_back(1'b1); end
    endtask

    initial forever begin @(posedge clk); cyc++; end

    // monitor and acknowledge responder, every cycle at the falling edge
    initial forever begin
        @(negedge clk);
        if (rst) begin
            cmd_ack = 1'b0; last_ack = -1; ack_due = -1; n_mrs = 0;
            first_cmd = 1; rst_fell = 0; last_zq = 0;
            p_act = 0; p_rstn = 0; p_cke = 0; p_valid = 0; p_done = 0;
        end else begin
            cmd_ack = (cyc == ack_due);
            if (init_active && !p_act) t_act = cyc;
            if (mem_rst_n && !p_rstn) begin
                check(cyc - t_act == N_RST, "R2", "reset hold", cyc - t_act, N_RST);
                t_rstn = cyc;
            end
            if (!mem_rst_n && p_rstn) rst_fell = 1;
            if (cke && !p_cke) begin
                check(cyc - t_rstn == N_CKE, "R2", "cke wait", cyc - t_rstn, N_CKE);
                t_cke = cyc;
            end
            if (cmd_valid && p_valid) check(0, "R8", "strobe width", 2, 1);
            if (cmd_valid) begin
                if (first_cmd)
                    check(cyc - t_cke >= N_SET + 1, "R3", "settle", cyc - t_cke, N_SET + 1);
                first_cmd = 0;
                if (q_addr.size() == 0) begin
                    check(0, tag, "unexpected command", cmd_addr, 0);
                end else begin
                    check(cmd_addr == q_addr[0], q_zq[0] ? "R9" : tag, "command word",
                          cmd_addr, q_addr[0]);
                    check(cmd_is_zq == q_zq[0], "R9", "zq flag", cmd_is_zq, q_zq[0]);
                    void'(q_addr.pop_front()); void'(q_zq.pop_front());
                end
                if (last_ack >= 0) begin
                    if (last_zq) check(cyc - last_ack == 513, "R9", "zq spacing",
                                       cyc - last_ack, 513);
                    else         check(cyc - last_ack >= 13, "R8", "mrs gap",
                                       cyc - last_ack, 13);
                end
                if (!cmd_is_zq) n_mrs++;
                cur_zq  = cmd_is_zq;
                ack_due = cyc + 1 + (n_mrs % 3);
            end
            if (cyc == ack_due) begin last_ack = cyc; last_zq = cur_zq; end
            if (done && !p_done) begin
                check(cyc - last_ack == 513, "R10", "done delay", cyc - last_ack, 513);
                check(!init_active, "R10", "active low at done", init_active, 0);
                check(q_addr.size() == 0, "R10", "commands left", q_addr.size(), 0);
            end
            p_act = init_active; p_rstn = mem_rst_n; p_cke = cke;
            p_valid = cmd_valid; p_done = done;
        end
    end

    task automatic run(input string t, input logic [7:0] pres, input logic [7:0] mir,
                       input bit rd, input bit busy_req, input int mrs_exp);
        tag = t; cs_present = pres; cs_mirror = mir; rdimm = rd;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!mem_rst_n && !cke && !cmd_valid && !done && !init_active, "R1",
              "outputs in reset", {mem_rst_n, cke, cmd_valid, done, init_active}, 0);
        build_expect();
        rst = 1'b0;
        @(negedge clk);
        check(!mem_rst_n && !cke && !done, "R1", "idle after reset",
              {mem_rst_n, cke, done}, 0);
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        if (busy_req) begin
            while (!cke) @(negedge clk);
            repeat (5) @(negedge clk);
            init_req = 1'b1;
            @(negedge clk);
            init_req = 1'b0;
        end
        for (int i = 0; i < 30000 && !done; i++) @(negedge clk);
        check(done, t, "sequence finished", done, 1);
        check(!rst_fell, "R11", "reset pin stayed released", rst_fell, 0);
        check(n_mrs == mrs_exp, (rd ? "R6" : "R7"), "mode-register writes", n_mrs, mrs_exp);
    endtask

    initial begin
        run("R5", 8'b0000_1100, 8'b0000_0100, 1'b0, 1'b0, 4);   // mirrored first CS
        run("R4", 8'b0000_1100, 8'b0000_0000, 1'b0, 1'b0, 4);   // plain word layout, R7
        run("R6", 8'b1010_0101, 8'hFF,        1'b1, 1'b0, 16);  // registered, no swap
        run("R9", 8'b0000_0000, 8'h00,        1'b0, 1'b0, 0);   // only calibration
        run("R11", 8'b1000_0000, 8'h80,       1'b0, 1'b1, 4);   // request while busy
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule